// File: doc/BRIEF.md
# Paired-halfword long branch-link sequencer

This block carries out a long subroutine call that arrives as two consecutive 16-bit halfwords. Each decoded halfword brings a 2-bit kind field, an 11-bit offset slice and its own address. The current link register value comes in alongside. The first halfword of a pair (the prefix) builds a partial target and writes it to the link register. The second halfword (the suffix) adds the low offset slice to that link value and branches there. One suffix form stays in the compact 16-bit instruction set. The other switches to the 32-bit instruction set and forces the target onto a word boundary. Either suffix leaves a return address, with bit 0 set, in the link register.

The block remembers whether a prefix is outstanding and at which address it sat. From this it detects broken pairs: a suffix with no prefix in front of it, a suffix that is not at the prefix address plus 2, or a prefix that is followed by something other than a suffix. It also detects the undefined encoding of the state-switching suffix. A kind value of 00 is not part of the sequence. The block passes it on as an unconditional branch. All address arithmetic wraps modulo 2^32.

Top module: `long_call_seq`

## Requirements
- R1: A halfword with kind 10 (prefix) raises `lr_we` one cycle later, with `lr_out` = address + 4 + (sign-extended offset << 12), computed modulo 2^32. It does not raise `pc_we`.
- R2: A kind 11 suffix at the prefix address + 2 raises `pc_we` and `lr_we` one cycle later. It gives `pc_out` = `lr_in` + (offset << 1), `lr_out` = (address + 2) | 1 and `t_flag` = 1.
- R3: A kind 01 suffix at the prefix address + 2 with offset bit 0 equal to 0 gives `pc_out` = (`lr_in` + (offset << 1)) & ~3, `lr_out` = (address + 2) | 1 and `t_flag` = 0 (32-bit instruction set).
- R4: A halfword with kind 00 raises `b_uncond` for one cycle. It writes neither PC nor link, and it ends any outstanding prefix.
- R5: A kind 01 halfword with offset bit 0 equal to 1 raises `undef`. It writes neither PC nor link, and `t_flag` keeps its value.
- R6: A suffix (kind 11 or 01) with no outstanding prefix, or not at the prefix address + 2, raises `pair_err`. It writes neither PC nor link.
- R7: A kind 10 or kind 00 halfword that arrives while a prefix is outstanding raises `pair_err`. A new prefix still loads the link register and becomes the outstanding prefix.
- R8: After reset all strobes (`pc_we`, `lr_we`, `undef`, `pair_err`, `b_uncond`) are 0, `t_flag` is 1 and no prefix is outstanding.
- R9: Cycles with `hw_valid` low leave the outstanding prefix untouched and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_valid | input | 1 | A decoded halfword is presented this cycle |
| hw_kind | input | 2 | Kind field: 10 prefix, 11 compact suffix, 01 switching suffix, 00 plain branch |
| hw_off | input | 11 | Offset slice carried by the halfword |
| hw_addr | input | 32 | Address of the halfword |
| lr_in | input | 32 | Current link register value |
| pc_we | output | 1 | Branch taken; load PC from `pc_out` |
| pc_out | output | 32 | Branch target |
| lr_we | output | 1 | Load link register from `lr_out` |
| lr_out | output | 32 | New link value |
| t_flag | output | 1 | Instruction-set state: 1 compact, 0 32-bit |
| undef | output | 1 | Undefined encoding seen |
| pair_err | output | 1 | Pairing violation seen |
| b_uncond | output | 1 | Kind 00 halfword, handed off as an unconditional branch |

## Verification
Every result is registered. The strobes and values that belong to a halfword accepted on one rising edge appear just after that edge and last exactly one cycle. The bench drives each halfword on a falling edge. It compares all outputs on the next falling edge, so the single register stage sits between stimulus and sample. Only then does it withdraw or replace the input. Idle gaps are sampled the same way to show that no strobe appears and that a pending prefix survives the gap.

// File: rtl/long_call_seq.sv
module long_call_seq #(
  parameter int AW = 32,
  parameter int OW = 11,
  parameter int HI_SHIFT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_valid,
  input  logic [1:0]    hw_kind,
  input  logic [OW-1:0] hw_off,
  input  logic [AW-1:0] hw_addr,
  input  logic [AW-1:0] lr_in,
  output logic          pc_we,
  output logic [AW-1:0] pc_out,
  output logic          lr_we,
  output logic [AW-1:0] lr_out,
  output logic          t_flag,
  output logic          undef,
  output logic          pair_err,
  output logic          b_uncond
);
  localparam int EXT = AW - OW;

  logic          pend_q;
  logic [AW-1:0] pend_addr_q;

  wire is_pre  = hw_kind == 2'b10;
  wire is_suf  = hw_kind[0];
  wire is_sw   = hw_kind == 2'b01;
  wire is_b    = hw_kind == 2'b00;

  wire [AW-1:0] hi_part  = {{EXT{hw_off[OW-1]}}, hw_off} << HI_SHIFT;
  wire [AW-1:0] pre_lr   = hw_addr + AW'(4) + hi_part;
  wire [AW-1:0] suf_sum  = lr_in + {{(EXT-1){1'b0}}, hw_off, 1'b0};
  wire [AW-1:0] ret_addr = (hw_addr + AW'(2)) | AW'(1);

  wire paired  = pend_q && (hw_addr == pend_addr_q + AW'(2));
  wire bad_enc = is_sw && hw_off[0];
  wire go      = is_suf && paired && !bad_enc;
  wire broken  = is_suf ? !paired : pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pc_we       <= 1'b0;
      pc_out      <= '0;
      lr_we       <= 1'b0;
      lr_out      <= '0;
      t_flag      <= 1'b1;
      undef       <= 1'b0;
      pair_err    <= 1'b0;
      b_uncond    <= 1'b0;
    end else begin
      pc_we    <= hw_valid && go;
      lr_we    <= hw_valid && (go || is_pre);
      undef    <= hw_valid && bad_enc;
      pair_err <= hw_valid && broken;
      b_uncond <= hw_valid && is_b;
      if (hw_valid) begin
        pend_q <= is_pre;
        if (is_pre) begin
          pend_addr_q <= hw_addr;
          lr_out      <= pre_lr;
        end
        if (go) begin
          pc_out <= is_sw ? (suf_sum & ~AW'(3)) : suf_sum;
          lr_out <= ret_addr;
          t_flag <= !is_sw;
        end
      end
    end
  end

  assert_switch_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && !t_flag) |-> (pc_out[1:0] == 2'b00));
  assert_link_odd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (lr_we && lr_out[0]));
  assert_undef_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (!pc_we && !lr_we));
  assert_uncond_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    b_uncond |-> (!pc_we && !lr_we));
  assert_lone_suffix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && hw_kind[0] && !pend_q) |=> (pair_err && !pc_we));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_valid |=> !(pc_we || lr_we || undef || pair_err || b_uncond));
endmodule

// File: tb/long_call_seq_test.sv
module long_call_seq_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic        rst_n, hw_valid;
  logic [1:0]  hw_kind;
  logic [10:0] hw_off;
  logic [31:0] hw_addr, lr_in;
  logic        pc_we, lr_we, t_flag, undef, pair_err, b_uncond;
  logic [31:0] pc_out, lr_out;

  long_call_seq uut (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_kind(hw_kind),
    .hw_off(hw_off), .hw_addr(hw_addr), .lr_in(lr_in),
    .pc_we(pc_we), .pc_out(pc_out), .lr_we(lr_we), .lr_out(lr_out),
    .t_flag(t_flag), .undef(undef), .pair_err(pair_err), .b_uncond(b_uncond)
  );

  int vecs = 0;
  int errs = 0;
  logic        m_pend = 1'b0;
  logic [31:0] m_paddr = '0;
  logic        m_t = 1'b1;

  function automatic logic [69:0] observed();
    return {pc_we, pc_we ? pc_out : 32'h0, lr_we, lr_we ? lr_out : 32'h0,
            t_flag, undef, pair_err, b_uncond};
  endfunction

  task automatic check(input string tag, input logic [69:0] act, input logic [69:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] k, input logic [10:0] off,
                       input logic [31:0] a, input logic [31:0] lr);
    logic pre, suf, ok, und, go, perr, e_lrwe;
    logic [31:0] sum, e_pc, e_lr;
    logic [69:0] exp;
    string tag;
    @(negedge clk);
    hw_valid = 1'b1; hw_kind = k; hw_off = off; hw_addr = a; lr_in = lr;
    pre  = (k == 2'b10);
    suf  = k[0];
    ok   = m_pend && (a == m_paddr + 32'd2);
    und  = (k == 2'b01) && off[0];
    go   = suf && ok && !und;
    perr = suf ? !ok : m_pend;
    sum  = lr + {20'h0, off, 1'b0};
    e_pc = go ? ((k == 2'b01) ? (sum & 32'hFFFF_FFFC) : sum) : 32'h0;
    e_lrwe = go || pre;
    e_lr = pre ? (a + 32'd4 + ({{21{off[10]}}, off} << 12))
               : (go ? ((a + 32'd2) | 32'd1) : 32'h0);
    if (go) m_t = (k == 2'b11);
    exp = {go, e_pc, e_lrwe, e_lr, m_t, und, perr, k == 2'b00};
    if (suf && !ok)       tag = "R6";
    else if (und)         tag = "R5";
    else if (perr)        tag = "R7";
    else if (k == 2'b11)  tag = "R2";
    else if (k == 2'b01)  tag = "R3";
    else if (k == 2'b00)  tag = "R4";
    else                  tag = "R1";
    @(negedge clk);
    check(tag, observed(), exp);
    hw_valid = 1'b0;
    m_pend = pre;
    if (pre) m_paddr = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R9", observed(), {1'b0, 32'h0, 1'b0, 32'h0, m_t, 3'b000});
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errs++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] seed, a, lrv;
    logic [1:0] k;
    seed = $urandom(32'h5eed_0042);
    rst_n = 1'b0; hw_valid = 1'b0; hw_kind = '0; hw_off = '0; hw_addr = '0; lr_in = '0;
    repeat (3) @(negedge clk);
    check("R8", observed(), {1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 3'b000});
    rst_n = 1'b1;
    idle(2);

    apply(2'b10, 11'h7FF, 32'h0000_1000, 32'h0);
    apply(2'b11, 11'h123, 32'h0000_1002, 32'h0000_0004);
    apply(2'b10, 11'h001, 32'h0000_2002, 32'h0);
    apply(2'b01, 11'h0FE, 32'h0000_2004, 32'h0000_3006);
    apply(2'b10, 11'h3FF, 32'hFFFF_FFF0, 32'h0);
    apply(2'b01, 11'h0FF, 32'hFFFF_FFF2, 32'h003F_FFF4);
    apply(2'b11, 11'h010, 32'h0000_4000, 32'h0000_8000);
    apply(2'b10, 11'h010, 32'h0000_5000, 32'h0);
    apply(2'b11, 11'h010, 32'h0000_6000, 32'h0);
    apply(2'b10, 11'h020, 32'h0000_7000, 32'h0);
    apply(2'b10, 11'h021, 32'h0000_7002, 32'h0);
    apply(2'b11, 11'h001, 32'h0000_7004, 32'h0002_8006);
    apply(2'b10, 11'h000, 32'h0000_8000, 32'h0);
    apply(2'b00, 11'h055, 32'h0000_8002, 32'h0);
    apply(2'b11, 11'h001, 32'h0000_8004, 32'h0);
    apply(2'b10, 11'h400, 32'h0000_9000, 32'h0);
    idle(3);
    apply(2'b11, 11'h7FF, 32'h0000_9002, 32'hFFC0_9004);

    for (int i = 0; i < 600; i++) begin
      k = 2'($urandom());
      a = $urandom() & 32'hFFFF_FFFE;
      if (m_pend && ($urandom() % 4 != 0)) a = m_paddr + 32'd2;
      lrv = $urandom();
      apply(k, 11'($urandom()), a, lrv);
      if ($urandom() % 8 == 0) idle(1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule